// File: doc/BRIEF.md
# Indirect Register Mailbox Bridge

This block gives a processor access to a small 8-bit register file inside a serial engine through one 16-bit mailbox word. The processor writes the mailbox once. That write carries the access direction, a compact 6-bit register index and, for a store, the data byte. The bridge translates the compact index into the engine's native register offset. It then runs a request/ready handshake on the internal register bus and raises a completion flag in the mailbox.

For a load, the byte returned by the engine replaces the data field of the mailbox. Software writes the command, polls until the completion flag is set, and then reads the byte. Indices that have no native register behind them never reach the bus: they complete at once and a load from one of them returns zero.

Top module: `regmbox_bridge`

## Requirements
- R1: After reset the mailbox reads as 0x0000 and no internal request is pending.
- R2: A mailbox write while idle starts exactly one internal access. `ib_req` is high from the next cycle. `ib_we` equals the inverse of write bit 14 (bit 14 = 1 means load, 0 means store), and `ib_wdata` equals write bits 7:0.
- R3: The compact index in write bits 13:8 is translated as follows. Indices 0x00–0x05, 0x0B–0x0E and 0x10 keep their value. Index 0x06 becomes 0x0A. Indices 0x07–0x0A become 0x06–0x09. Index 0x0F becomes 0x60. Indices 0x11–0x1B become 0x12–0x1C.
- R4: Mailbox bit 15 (done flag) reads 0 while a launched access is pending. Bits 14:8 always read as 0.
- R5: An access finishes on the clock edge where `ib_req` and `ib_ready` are both high. From the next cycle `ib_req` is low and bit 15 is 1.
- R6: On completion of a load, mailbox bits 7:0 hold the byte that was on `ib_rdata` at the completing edge. A store leaves the written byte in bits 7:0.
- R7: A mailbox write while an access is pending is ignored. The pending address, direction and data are unchanged, and the final mailbox value is that of the first access.
- R8: An index from 0x1C to 0x3F raises no request and sets bit 15 in the cycle after the write. A load from such an index returns 0x00 in bits 7:0.
- R9: While `ib_req` is high and `ib_ready` is low, `ib_addr`, `ib_we` and `ib_wdata` are held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Mailbox write strobe |
| cpu_wdata | input | 15 | Mailbox write value: bit 14 direction, bits 13:8 index, bits 7:0 data |
| cpu_rdata | output | 16 | Mailbox read value: bit 15 done, bits 7:0 data |
| ib_req | output | 1 | Internal access request |
| ib_we | output | 1 | Internal access is a store |
| ib_addr | output | 8 | Native register offset |
| ib_wdata | output | 8 | Store data |
| ib_rdata | input | 8 | Load data from the register file |
| ib_ready | input | 1 | Access accepted by the register file |

## Verification
The assertions assume that the register file raises `ib_ready` only while `ib_req` is high, and that the mailbox strobe lasts one cycle. They also assume that `ib_rdata` is valid in the cycle `ready` is seen. The bench's responder raises ready only against a live request, and each strobe is pulsed for a single cycle. Writes during a pending access are issued on purpose, under a long ready delay, so the ignore rule is exercised without breaking those assumptions.

// File: rtl/regmbox_bridge.sv
module regmbox_bridge #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int NAT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_wr_en,
  input  logic [DATA_W+ADDR_W:0]     cpu_wdata,
  output logic [DATA_W+ADDR_W+1:0]   cpu_rdata,
  output logic                       ib_req,
  output logic                       ib_we,
  output logic [NAT_W-1:0]           ib_addr,
  output logic [DATA_W-1:0]          ib_wdata,
  input  logic [DATA_W-1:0]          ib_rdata,
  input  logic                       ib_ready
);
  localparam int RNW_B = DATA_W + ADDR_W;

  logic              busy, done, rnw_q;
  logic [NAT_W-1:0]  nat_q;
  logic [DATA_W-1:0] dat_q;

  logic [ADDR_W-1:0] idx;
  logic              cmd_rd;
  logic [NAT_W-1:0]  map_a;
  logic              map_ok;
  int                ai;

  assign idx    = cpu_wdata[RNW_B-1:DATA_W];
  assign cmd_rd = cpu_wdata[RNW_B];

  always_comb begin
    ai     = int'(idx);
    map_ok = 1'b1;
    map_a  = NAT_W'(ai);
    if (ai == 6)
      map_a = NAT_W'(10);
    else if (ai >= 7 && ai <= 10)
      map_a = NAT_W'(ai - 1);
    else if (ai == 15)
      map_a = NAT_W'(96);
    else if (ai >= 17 && ai <= 27)
      map_a = NAT_W'(ai + 1);
    else if (ai > 27) begin
      map_ok = 1'b0;
      map_a  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rnw_q <= 1'b0;
      nat_q <= '0;
      dat_q <= '0;
    end else if (busy) begin
      if (ib_ready) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (rnw_q) dat_q <= ib_rdata;
      end
    end else if (cpu_wr_en) begin
      rnw_q <= cmd_rd;
      nat_q <= map_a;
      busy  <= map_ok;
      done  <= !map_ok;
      dat_q <= (cmd_rd && !map_ok) ? '0 : cpu_wdata[DATA_W-1:0];
    end
  end

  assign ib_req    = busy;
  assign ib_we     = !rnw_q;
  assign ib_addr   = nat_q;
  assign ib_wdata  = dat_q;
  assign cpu_rdata = {done, {(ADDR_W+1){1'b0}}, dat_q};
endmodule

// File: rtl/regmbox_bridge_chk.sv
module regmbox_bridge_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int NAT_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cpu_wr_en,
  input logic [DATA_W+ADDR_W+1:0] cpu_rdata,
  input logic                     ib_req,
  input logic                     ib_we,
  input logic [NAT_W-1:0]         ib_addr,
  input logic [DATA_W-1:0]        ib_wdata,
  input logic                     ib_ready
);
  localparam int TOP = DATA_W + ADDR_W + 1;

  // R2
  req_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ib_req) |-> $past(cpu_wr_en));

  // R3
  no_gap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> (ib_addr != NAT_W'(15) && ib_addr != NAT_W'(17)));

  // R4
  done_low_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> !cpu_rdata[TOP]);

  // R4
  mid_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[TOP-1:DATA_W] == '0);

  // R5
  finish_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && ib_ready) |=> (!ib_req && cpu_rdata[TOP]));

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ready && cpu_wr_en) |=> $stable(cpu_rdata[DATA_W-1:0]));

  // R9
  hold_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ready) |=>
      (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)));
endmodule

bind regmbox_bridge regmbox_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NAT_W(NAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_rdata(cpu_rdata),
  .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
  .ib_ready(ib_ready)
);

// File: tb/sim_regmbox_bridge.sv
module sim_regmbox_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, cpu_wr_en = 0, ib_ready = 0;
  logic [14:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        ib_req, ib_we;
  logic [7:0]  ib_addr, ib_wdata, ib_rdata;

  regmbox_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr),
    .ib_wdata(ib_wdata), .ib_rdata(ib_rdata), .ib_ready(ib_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ib_rdata = ib_addr ^ 8'hA5;

  int tests = 0, fails = 0, cycles = 0;
  int nat [64];
  int lat = 0, rcnt = 0;
  int seen_addr = -1, seen_cnt = 0;

  // reference model state
  bit m_busy, m_done, m_rd;
  int m_addr, m_data, m_wd;

  task automatic chk(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) nat[i] = -1;
    for (int i = 0; i <= 5; i++) nat[i] = i;
    nat[6] = 'h0A;
    for (int i = 7; i <= 10; i++) nat[i] = i - 1;
    for (int i = 11; i <= 14; i++) nat[i] = i;
    nat[15] = 'h60;
    nat[16] = 'h10;
    for (int i = 17; i <= 27; i++) nat[i] = i + 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rd = 0; m_addr = 0; m_data = 0; m_wd = 0;
    end else if (m_busy) begin
      if (ib_ready) begin
        m_busy = 0; m_done = 1;
        if (m_rd) m_data = (m_addr ^ 'hA5) & 'hFF;
      end
    end else if (cpu_wr_en) begin
      m_rd = cpu_wdata[14];
      if (nat[cpu_wdata[13:8]] >= 0) begin
        m_busy = 1; m_done = 0;
        m_addr = nat[cpu_wdata[13:8]];
        m_data = cpu_wdata[7:0];
      end else begin
        m_done = 1;
        m_addr = 0;
        m_data = m_rd ? 0 : cpu_wdata[7:0];
      end
    end
  end

  // responder and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5", cpu_rdata[15], m_done, "done flag");
      chk("R6", cpu_rdata[7:0], m_data, "data field");
      chk("R4", cpu_rdata[14:8], 0, "bits 14:8");
      chk("R2", ib_req, m_busy, "ib_req");
      if (ib_req) begin
        chk("R3", ib_addr, m_addr, "ib_addr");
        chk("R9", ib_we, !m_rd, "ib_we");
        chk("R9", ib_wdata, m_data, "ib_wdata");
      end
    end
    if (!ib_req) begin
      rcnt = 0; ib_ready = 0;
    end else begin
      seen_addr = ib_addr; seen_cnt++;
      ib_ready = (rcnt == lat);
      rcnt++;
    end
  end

  task automatic mbox(bit rd, int idx, int d);
    @(negedge clk);
    cpu_wr_en = 1; cpu_wdata = {rd, 6'(idx), 8'(d)};
    @(negedge clk);
    cpu_wr_en = 0;
    if (nat[idx] >= 0) begin
      chk("R4", cpu_rdata[15], 0, "done after launch");
      for (int k = 0; k < 50 && !cpu_rdata[15]; k++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", cpu_rdata, 0, "mailbox after reset");
    chk("R1", ib_req, 0, "req after reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", cpu_rdata, 0, "mailbox idle");

    for (int a = 0; a < 64; a++) begin
      for (int rd = 0; rd < 2; rd++) begin
        lat = (a + rd) % 4;
        seen_cnt = 0; seen_addr = -1;
        mbox(rd[0], a, (a * 7 + 3) & 'hFF);
        if (nat[a] >= 0) begin
          chk("R3", seen_addr, nat[a], $sformatf("native offset idx %0h", a));
          chk("R5", cpu_rdata[15], 1, "done after ready");
          chk("R6", cpu_rdata[7:0], rd ? ((nat[a] ^ 'hA5) & 'hFF) : ((a * 7 + 3) & 'hFF),
              "final data");
        end else begin
          chk("R8", seen_cnt, 0, "unmapped raised req");
          chk("R8", cpu_rdata[15], 1, "unmapped done");
          chk("R8", cpu_rdata[7:0], rd ? 0 : ((a * 7 + 3) & 'hFF), "unmapped data");
        end
      end
    end

    // ignore writes while pending
    lat = 6;
    @(negedge clk);
    cpu_wr_en = 1; cpu_wdata = {1'b1, 6'h06, 8'h11};
    @(negedge clk);
    cpu_wr_en = 0;
    @(negedge clk);
    cpu_wr_en = 1; cpu_wdata = {1'b0, 6'h0F, 8'h77};
    @(negedge clk);
    cpu_wr_en = 0;
    chk("R7", ib_addr, 'h0A, "addr after busy write");
    chk("R7", ib_we, 0, "dir after busy write");
    for (int k = 0; k < 20 && !cpu_rdata[15]; k++) @(negedge clk);
    chk("R7", cpu_rdata, 16'h8000 | (8'h0A ^ 8'hA5), "mailbox after ignored write");
    repeat (2) @(negedge clk);
    chk("R7", ib_req, 0, "no second access");

    // back-to-back: new launch clears done
    lat = 2;
    mbox(1'b0, 'h1B, 'h3C);
    chk("R3", seen_addr, 'h1C, "last mapped index");
    chk("R6", cpu_rdata, 16'h803C, "store result");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule